// File: doc/BRIEF.md
# Byte-Lane Data Buffer Enable Decoder

This block drives the output enables of three transceiver groups that sit between a 16-bit processor data path and a backplane carrying both 8-bit and 16-bit memory. The low-lane group carries data bits 7..0. The high-lane group carries bits 15..8 straight through. The swap group moves an odd-addressed byte onto bits 15..8 through a buffer of its own. A fourth output enables the processor's data-output drivers during writes.

Each cycle the decoder looks at the current bus operation: word write, byte write, read strobe and address bit 0. A transfer-active flag and an interrupt-acknowledge flag qualify the operation, and a flag that reports a 16-bit responder qualifies the low-lane read path. All outputs are active low and registered, so each decision appears one clock after the inputs are sampled. The bus write strobe plays no part in the decode, which lets write data reach the lines before the strobe. A word access to an 8-bit-only responder is not split into two byte cycles.

Top module: `bytelane_buf_ctl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, all four enables are high (inactive).
- R2: If the transfer-active flag was low, or the interrupt-acknowledge flag was high, at the previous clock edge, all four enables are high.
- R3: A qualified word write asserts (drives low) the low-lane and high-lane enables and leaves the swap enable high.
- R4: A qualified byte write with address bit 0 = 1 asserts only the swap enable among the three lane enables.
- R5: A qualified byte write with address bit 0 = 0 asserts only the low-lane enable among the three lane enables.
- R6: A qualified read (read strobe high, no write flag) asserts the high-lane enable, asserts the low-lane enable exactly when the 16-bit-responder flag is 1, and leaves the swap enable high.
- R7: The data-output enable is low exactly when the previous edge saw a qualified word or byte write, whatever the read strobe was.
- R8: When several operation flags are high together, word write wins over byte write, and byte write wins over read.
- R9: The high-lane and swap enables are never low in the same cycle.
- R10: Every enable reflects the inputs sampled at the immediately preceding clock edge (one cycle of latency). With no operation flag set, all enables are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_word_i | input | 1 | Current cycle is a 16-bit write |
| wr_byte_i | input | 1 | Current cycle is an 8-bit write |
| addr0_i | input | 1 | Address bit 0 (1 = odd byte) |
| rd_strobe_i | input | 1 | Read data strobe, active high |
| xfer_act_i | input | 1 | Backplane transfer in progress |
| intack_i | input | 1 | Interrupt-acknowledge cycle in progress |
| resp16_i | input | 1 | Addressed responder is 16 bits wide |
| lo_en_n_o | output | 1 | Low-lane buffer enable, active low |
| hi_en_n_o | output | 1 | High-lane buffer enable, active low |
| swap_en_n_o | output | 1 | Odd-byte swap buffer enable, active low |
| dout_en_n_o | output | 1 | Data-output driver enable, active low |

## Verification
A wrong operation class or a wrong lane decode shows at the enables one clock after the inputs that caused it. No state carries over between cycles, so each fault stays within one cycle and a sweep of all 128 input combinations exposes it. A wrong priority between flags shows up as two groups on one lane, or as a lane missing under mixed inputs. A missing qualification shows up as enables asserted during an idle or interrupt-acknowledge cycle.

// File: rtl/bytelane_pkg.sv
package bytelane_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_READ = 2'd1,
    OP_BYTE = 2'd2,
    OP_WORD = 2'd3
  } bus_op_e;

  localparam int unsigned LANE_EN_W = 4;

  // active-high enable set before output inversion
  typedef struct packed {
    logic lo;
    logic hi;
    logic swap;
    logic dout;
  } lane_en_t;

  // gate first, then word > byte > read priority
  function automatic bus_op_e fn_classify(input logic gate,
                                          input logic wr_word,
                                          input logic wr_byte,
                                          input logic rd);
    bus_op_e op;
    if (!gate)        op = OP_IDLE;
    else if (wr_word) op = OP_WORD;
    else if (wr_byte) op = OP_BYTE;
    else if (rd)      op = OP_READ;
    else              op = OP_IDLE;
    return op;
  endfunction

  function automatic lane_en_t fn_lanes(input bus_op_e op,
                                        input logic addr0,
                                        input logic resp16);
    lane_en_t e;
    e = '0;
    case (op)
      OP_WORD: begin
        e.lo   = 1'b1;
        e.hi   = 1'b1;
        e.dout = 1'b1;
      end
      OP_BYTE: begin
        e.swap = addr0;
        e.lo   = ~addr0;
        e.dout = 1'b1;
      end
      OP_READ: begin
        e.hi = 1'b1;
        e.lo = resp16;
      end
      default: e = '0;
    endcase
    return e;
  endfunction

endpackage

// File: rtl/bytelane_op_classify.sv
module bytelane_op_classify
  import bytelane_pkg::*;
(
  input  logic    wr_word_i,
  input  logic    wr_byte_i,
  input  logic    rd_strobe_i,
  input  logic    xfer_act_i,
  input  logic    intack_i,
  output logic    gate_o,
  output bus_op_e op_o
);
  always_comb begin
    gate_o = xfer_act_i & ~intack_i;
    op_o   = fn_classify(gate_o, wr_word_i, wr_byte_i, rd_strobe_i);
  end
endmodule

// File: rtl/bytelane_lane_map.sv
module bytelane_lane_map
  import bytelane_pkg::*;
(
  input  bus_op_e  op_i,
  input  logic     addr0_i,
  input  logic     resp16_i,
  output lane_en_t en_o
);
  always_comb en_o = fn_lanes(op_i, addr0_i, resp16_i);
endmodule

// File: rtl/bytelane_en_reg.sv
module bytelane_en_reg #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] en_i,
  output logic [WIDTH-1:0] en_n_o
);
  // one flop per enable, reset to the inactive (high) level
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_n_o[g] <= 1'b1;
      else        en_n_o[g] <= ~en_i[g];
    end
  end
endmodule

// File: rtl/bytelane_buf_ctl.sv
module bytelane_buf_ctl
  import bytelane_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_word_i,
  input  logic wr_byte_i,
  input  logic addr0_i,
  input  logic rd_strobe_i,
  input  logic xfer_act_i,
  input  logic intack_i,
  input  logic resp16_i,
  output logic lo_en_n_o,
  output logic hi_en_n_o,
  output logic swap_en_n_o,
  output logic dout_en_n_o
);
  // named internal events
  logic                 xfer_gate;
  bus_op_e              cur_op;
  lane_en_t             next_en;
  logic [LANE_EN_W-1:0] en_n_q;

  bytelane_op_classify u_classify (
    .wr_word_i   (wr_word_i),
    .wr_byte_i   (wr_byte_i),
    .rd_strobe_i (rd_strobe_i),
    .xfer_act_i  (xfer_act_i),
    .intack_i    (intack_i),
    .gate_o      (xfer_gate),
    .op_o        (cur_op)
  );

  bytelane_lane_map u_map (
    .op_i     (cur_op),
    .addr0_i  (addr0_i),
    .resp16_i (resp16_i),
    .en_o     (next_en)
  );

  bytelane_en_reg #(.WIDTH(LANE_EN_W)) u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (next_en),
    .en_n_o (en_n_q)
  );

  // struct packing order: lo, hi, swap, dout (MSB first)
  assign lo_en_n_o   = en_n_q[3];
  assign hi_en_n_o   = en_n_q[2];
  assign swap_en_n_o = en_n_q[1];
  assign dout_en_n_o = en_n_q[0];
endmodule

// File: rtl/bytelane_buf_ctl_chk.sv
module bytelane_buf_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_word_i,
  input logic wr_byte_i,
  input logic addr0_i,
  input logic rd_strobe_i,
  input logic xfer_act_i,
  input logic intack_i,
  input logic resp16_i,
  input logic lo_en_n_o,
  input logic hi_en_n_o,
  input logic swap_en_n_o,
  input logic dout_en_n_o
);
  logic seen;
  logic qual;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end
  assign qual = xfer_act_i & ~intack_i;

  p_gate_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !$past(qual)) |->
      (lo_en_n_o && hi_en_n_o && swap_en_n_o && dout_en_n_o));

  p_word_lanes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(qual && wr_word_i)) |->
      (!lo_en_n_o && !hi_en_n_o && swap_en_n_o));

  p_odd_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(qual && !wr_word_i && wr_byte_i && addr0_i)) |->
      (!swap_en_n_o && lo_en_n_o && hi_en_n_o));

  p_even_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(qual && !wr_word_i && wr_byte_i && !addr0_i)) |->
      (!lo_en_n_o && hi_en_n_o && swap_en_n_o));

  p_read_lanes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(qual && !wr_word_i && !wr_byte_i && rd_strobe_i)) |->
      (!hi_en_n_o && swap_en_n_o && (lo_en_n_o == !$past(resp16_i))));

  p_dout_r7: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> (dout_en_n_o == !$past(qual && (wr_word_i || wr_byte_i))));

  p_no_clash_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(!hi_en_n_o && !swap_en_n_o));

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(!wr_word_i && !wr_byte_i && !rd_strobe_i)) |->
      (lo_en_n_o && hi_en_n_o && swap_en_n_o && dout_en_n_o));
endmodule

bind bytelane_buf_ctl bytelane_buf_ctl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_word_i   (wr_word_i),
  .wr_byte_i   (wr_byte_i),
  .addr0_i     (addr0_i),
  .rd_strobe_i (rd_strobe_i),
  .xfer_act_i  (xfer_act_i),
  .intack_i    (intack_i),
  .resp16_i    (resp16_i),
  .lo_en_n_o   (lo_en_n_o),
  .hi_en_n_o   (hi_en_n_o),
  .swap_en_n_o (swap_en_n_o),
  .dout_en_n_o (dout_en_n_o)
);

// File: tb/bytelane_buf_ctl_tb.sv
module bytelane_buf_ctl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_word = 1'b0, wr_byte = 1'b0, addr0 = 1'b0, rd = 1'b0;
  logic xfer = 1'b0, intack = 1'b0, resp16 = 1'b0;
  logic lo_n, hi_n, swap_n, dout_n;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  bytelane_buf_ctl u_dut (
    .clk(clk), .rst_n(rst_n),
    .wr_word_i(wr_word), .wr_byte_i(wr_byte), .addr0_i(addr0),
    .rd_strobe_i(rd), .xfer_act_i(xfer), .intack_i(intack), .resp16_i(resp16),
    .lo_en_n_o(lo_n), .hi_en_n_o(hi_n), .swap_en_n_o(swap_n), .dout_en_n_o(dout_n)
  );

  // expected {lo,hi,swap,dout} active low, written as a case table on the vector
  function automatic logic [3:0] exp_en(input logic [6:0] v);
    // v = {xfer, intack, wr_word, wr_byte, rd, addr0, resp16}
    logic [3:0] act;
    act = 4'b0000;
    if (v[6] && !v[5]) begin
      casez (v[4:0])
        5'b1????: act = 4'b1101;
        5'b01?1?: act = 4'b0011;
        5'b01?0?: act = 4'b1001;
        5'b001?1: act = 4'b1100;
        5'b001?0: act = 4'b0100;
        default:  act = 4'b0000;
      endcase
    end
    return ~act;
  endfunction

  function automatic string tag_of(input logic [6:0] v);
    int nops;
    nops = int'(v[4]) + int'(v[3]) + int'(v[2]);
    if (!v[6] || v[5])  return "R2";
    if (nops > 1)       return "R8";
    if (v[4])           return "R3";
    if (v[3] && v[1])   return "R4";
    if (v[3])           return "R5";
    if (v[2])           return "R6";
    return "R10";
  endfunction

  task automatic check4(input string tag, input logic [3:0] exp);
    logic [3:0] got;
    got = {lo_n, hi_n, swap_n, dout_n};
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: enables {lo,hi,swap,dout}_n got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic check_misc(input logic [3:0] exp_q);
    // R7 data-output enable and R9 lane exclusivity, checked on their own
    n_cmp++;
    if (dout_n !== exp_q[0]) begin
      n_bad++;
      $display("FAIL R7: dout_en_n got %b expected %b", dout_n, exp_q[0]);
    end
    n_cmp++;
    if (!hi_n && !swap_n) begin
      n_bad++;
      $display("FAIL R9: hi_n=%b swap_n=%b expected not both 0", hi_n, swap_n);
    end
  endtask

  task automatic apply(input logic [6:0] v);
    {xfer, intack, wr_word, wr_byte, rd, addr0, resp16} = v;
  endtask

  // drive at a falling edge, check at the next falling edge
  task automatic run_vec(input logic [6:0] v);
    apply(v);
    @(negedge clk);
    check4(tag_of(v), exp_en(v));
    check_misc(exp_en(v));
  endtask

  initial begin
    // R1: reset with an active word write on the inputs
    apply(7'b1010000);
    repeat (3) @(negedge clk);
    check4("R1", 4'b1111);
    rst_n = 1'b1;
    apply(7'b0000000);
    @(negedge clk);
    check4("R1", 4'b1111);

    // directed corners
    run_vec(7'b1010100);  // R3 word write with read strobe: R8
    run_vec(7'b1001010);  // R4 odd byte write
    run_vec(7'b1001000);  // R5 even byte write
    run_vec(7'b1000101);  // R6 read, 16-bit responder
    run_vec(7'b1000100);  // R6 read, 8-bit responder
    run_vec(7'b1101010);  // R2 interrupt acknowledge blocks
    run_vec(7'b0010100);  // R2 no transfer
    run_vec(7'b1001110);  // R8 byte odd with read: no hi lane
    run_vec(7'b1000011);  // R10 no operation

    // R10 latency: output flips exactly one edge after input change
    apply(7'b1010000);
    @(posedge clk);
    #1;
    check4("R10", exp_en(7'b1010000));
    apply(7'b0000000);
    #2;
    check4("R10", exp_en(7'b1010000));
    @(negedge clk);

    // exhaustive sweep
    for (int i = 0; i < 128; i++) run_vec(7'(i));

    // random sequence, fixed seed
    void'($urandom(32'h5eed_b17e));
    for (int k = 0; k < 600; k++) run_vec(7'($urandom()));

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule